// File: doc/BRIEF.md
# Fuse Trim Programming Controller

This block is the digital programming sequencer of a trimmable linear sensor. It receives single-cycle event strobes from an upstream pulse classifier: one strobe for a mid-level programming pulse and one for a high-level pulse. It also receives a power-on reset. The sequence is driven purely by pulse counts through a fixed order of states:

1. A high pulse opens register selection.
2. Mid pulses count a key that picks the target register.
3. A second high pulse enters code addressing.
4. Further mid pulses raise a trial code.
5. A final high pulse commands one fuse bit to be blown.

After the blow, the controller waits for a power cycle.

The fuse states are held in registers that the power-on reset does not clear. They are cleared only by a separate blank-part initialisation input. The trial code is volatile and is lost on every power cycle. The block drives the effective trim codes to the analog DACs at all times. Each effective code is the blown fuses ORed with the trial code. Code 5, for example, is built by blowing code 4 in one session and code 1 in another. Blowing the lock bit freezes all further programming.

Top module: `trim_prog_ctrl`

## Requirements
- R1: After power-on reset (rst_n low at a clock edge), the state is Initial (state code 0), the trial code is zero, and blow_req and blow_err are 0. While in Initial, mid pulses are ignored: the state and the codes do not change.
- R2: A high pulse in Initial moves the state to Selection (code 1). In Selection, each mid pulse raises the key by one, saturating at 3.
- R3: A high pulse in Selection moves the state to Addressing (code 2) when the key is 1 (sensitivity register) or 2 (offset/lock register). For any other key it moves to Void (code 4), where every pulse is ignored until power-on reset.
- R4: In Addressing, each mid pulse raises the trial code by one, saturating at 63. The result appears on sens_code (key 1) or on the low five bits in voq_code (key 2) one clock after the pulse.
- R5: A high pulse in Addressing with exactly one trial bit set blows that bit. blow_req is 1 for exactly one cycle, with blow_bit equal to the bit index and blow_reg equal to the key. The state becomes Halt (code 3).
- R6: In Halt, all pulses are ignored until power-on reset. The state, codes and blow_req stay unchanged.
- R7: A high pulse in Addressing with zero or several trial bits set is rejected. blow_req stays 0, blow_err becomes 1 until power-on reset, no fuse changes, and the state becomes Halt.
- R8: Power-on reset clears the trial code but not the fuses. Each effective code is the fuses ORed with the trial code, so blows in separate sessions accumulate.
- R9: Bit 5 of the key-2 register is the lock fuse and drives locked. While locked is 1, a high pulse in Initial is ignored, so no register can be reached.
- R10: fuse_init_n low at a clock edge clears all fuses (blank part).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset; clears volatile state only |
| fuse_init_n | input | 1 | Synchronous active-low blank-part fuse clear |
| mid_evt | input | 1 | One-cycle strobe: mid-level pulse seen |
| high_evt | input | 1 | One-cycle strobe: high-level pulse seen |
| sens_code | output | 6 | Effective sensitivity trim code |
| voq_code | output | 5 | Effective quiescent-output trim code |
| locked | output | 1 | Lock fuse blown |
| blow_req | output | 1 | One-cycle command to blow a fuse |
| blow_bit | output | 3 | Bit index of the fuse to blow |
| blow_reg | output | 2 | Register (key) of the fuse to blow |
| blow_err | output | 1 | Last blow request rejected (not one-hot) |
| state | output | 3 | Sequencer state: 0 Initial, 1 Selection, 2 Addressing, 3 Halt, 4 Void |

## Verification
Every result registers on the first clock edge that samples its strobe. The new state and the new code are therefore visible one cycle after a pulse. blow_req is high during exactly that one following cycle. The bench drives each strobe for one cycle from the falling edge, reads all outputs at the next falling edge, and confirms that blow_req has dropped one cycle later. Fuse persistence is checked across rst_n pulses that leave fuse_init_n high.

// File: rtl/trim_pkg.sv
// Package: shared types and sizes for the fuse trim programming controller.
// Assumes: state encoding is observed at the top port, so values are fixed.
package trim_pkg;
    localparam int KEY_W = 2;

    typedef enum logic [2:0] {
        ST_INIT = 3'd0,
        ST_SEL  = 3'd1,
        ST_ADDR = 3'd2,
        ST_HALT = 3'd3,
        ST_VOID = 3'd4
    } prog_state_e;
endpackage

// File: rtl/trim_seq.sv
// Module: pulse-count sequencer. Walks Initial -> Selection -> Addressing,
// counts the key and the trial code, and raises blow_go for a high pulse
// in Addressing. Assumes mid_evt and high_evt are single-cycle strobes;
// a high pulse wins if both arrive together.
module trim_seq
    import trim_pkg::*;
#(
    parameter int CODE_W   = 6,
    parameter int NUM_REGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mid_evt,
    input  logic              high_evt,
    input  logic              locked,
    output prog_state_e       state,
    output logic [KEY_W-1:0]  key,
    output logic [CODE_W-1:0] trial,
    output logic              blow_go
);
    localparam logic [KEY_W-1:0]  KEY_MAX  = '1;
    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    logic key_ok;
    assign key_ok  = (key != '0) && (int'(key) <= NUM_REGS);
    assign blow_go = (state == ST_ADDR) && high_evt;

    // State transitions driven by high pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_INIT;
        end else if (high_evt) begin
            unique case (state)
                ST_INIT: if (!locked) state <= ST_SEL;
                ST_SEL:  state <= key_ok ? ST_ADDR : ST_VOID;
                ST_ADDR: state <= ST_HALT;
                default: state <= state;
            endcase
        end
    end

    // Key and trial code counters driven by mid pulses, both saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key   <= '0;
            trial <= '0;
        end else if (mid_evt && !high_evt) begin
            if (state == ST_SEL && key != KEY_MAX)    key   <= key + 1'b1;
            if (state == ST_ADDR && trial != CODE_MAX) trial <= trial + 1'b1;
        end
    end

    a_r4_code_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && mid_evt && !high_evt && trial != CODE_MAX)
        |=> trial == CODE_W'($past(trial) + 1'b1));
    a_r6_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> (state == ST_HALT));
    a_r3_void_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_VOID) |=> (state == ST_VOID && $stable(trial)));
    a_r9_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && state == ST_INIT) |=> (state == ST_INIT));
endmodule

// File: rtl/trim_fuse_bank.sv
// Module: non-volatile fuse store and blow command issue. Fuses are cleared
// only by fuse_init_n; the blow command and error flag are volatile.
// Assumes blow_go arrives only with a valid key (1..NUM_REGS).
module trim_fuse_bank
    import trim_pkg::*;
#(
    parameter int CODE_W   = 6,
    parameter int NUM_REGS = 2,
    localparam int BIT_W   = $clog2(CODE_W)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            fuse_init_n,
    input  logic                            blow_go,
    input  logic [KEY_W-1:0]                key,
    input  logic [CODE_W-1:0]               trial,
    output logic [NUM_REGS-1:0][CODE_W-1:0] fuse_q,
    output logic                            blow_req,
    output logic [BIT_W-1:0]                blow_bit,
    output logic [KEY_W-1:0]                blow_reg,
    output logic                            blow_err
);
    logic             one_hot;
    logic [BIT_W-1:0] bit_idx;

    assign one_hot = $onehot(trial);

    // Encode the index of the single set trial bit.
    always_comb begin
        bit_idx = '0;
        for (int i = 0; i < CODE_W; i++)
            if (trial[i]) bit_idx = BIT_W'(i);
    end

    // One fuse word per register, ORed with the accepted blow.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_fuse
        always_ff @(posedge clk) begin
            if (!fuse_init_n)
                fuse_q[g] <= '0;
            else if (blow_go && one_hot && key == KEY_W'(g + 1))
                fuse_q[g] <= fuse_q[g] | trial;
        end
    end

    // Blow command strobe, its address, and the sticky rejection flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blow_req <= 1'b0;
            blow_bit <= '0;
            blow_reg <= '0;
            blow_err <= 1'b0;
        end else begin
            blow_req <= blow_go && one_hot;
            if (blow_go && one_hot) begin
                blow_bit <= bit_idx;
                blow_reg <= key;
            end
            if (blow_go && !one_hot) blow_err <= 1'b1;
        end
    end

    a_r8_fuse_keep: assert property (@(posedge clk) disable iff (!fuse_init_n)
        1'b1 |=> ((fuse_q & $past(fuse_q)) == $past(fuse_q)));
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        blow_req |=> !blow_req);
    a_r7_req_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(blow_req && blow_err));
endmodule

// File: rtl/trim_prog_ctrl.sv
// Module: top of the fuse trim programming controller. Joins the sequencer
// and the fuse bank, and forms the effective DAC codes as fuses OR trial.
// Assumes register 1 is sensitivity and register 2 holds offset bits below
// the top bit, which is the lock fuse.
module trim_prog_ctrl
    import trim_pkg::*;
#(
    parameter int CODE_W   = 6,
    parameter int NUM_REGS = 2,
    localparam int BIT_W   = $clog2(CODE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fuse_init_n,
    input  logic              mid_evt,
    input  logic              high_evt,
    output logic [CODE_W-1:0] sens_code,
    output logic [CODE_W-2:0] voq_code,
    output logic              locked,
    output logic              blow_req,
    output logic [BIT_W-1:0]  blow_bit,
    output logic [KEY_W-1:0]  blow_reg,
    output logic              blow_err,
    output logic [2:0]        state
);
    prog_state_e                     st;
    logic [KEY_W-1:0]                key;
    logic [CODE_W-1:0]               trial;
    logic                            blow_go;
    logic [NUM_REGS-1:0][CODE_W-1:0] fuse_q;
    logic [CODE_W-1:0]               trial_s, trial_q;

    trim_seq #(.CODE_W(CODE_W), .NUM_REGS(NUM_REGS)) u_seq (
        .clk(clk), .rst_n(rst_n), .mid_evt(mid_evt), .high_evt(high_evt),
        .locked(locked), .state(st), .key(key), .trial(trial),
        .blow_go(blow_go)
    );

    trim_fuse_bank #(.CODE_W(CODE_W), .NUM_REGS(NUM_REGS)) u_bank (
        .clk(clk), .rst_n(rst_n), .fuse_init_n(fuse_init_n),
        .blow_go(blow_go), .key(key), .trial(trial), .fuse_q(fuse_q),
        .blow_req(blow_req), .blow_bit(blow_bit), .blow_reg(blow_reg),
        .blow_err(blow_err)
    );

    // Steer the trial code only to the register the key selected.
    always_comb begin
        trial_s = (key == KEY_W'(1)) ? trial : '0;
        trial_q = (key == KEY_W'(2)) ? trial : '0;
    end

    assign sens_code = fuse_q[0] | trial_s;
    assign voq_code  = fuse_q[1][CODE_W-2:0] | trial_q[CODE_W-2:0];
    assign locked    = fuse_q[1][CODE_W-1];
    assign state     = st;

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (state == 3'd0 && !blow_req && !blow_err));
endmodule

// File: tb/tb_trim_prog_ctrl.sv
module tb_trim_prog_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0, fuse_init_n = 1'b0, mid_evt = 1'b0, high_evt = 1'b0;
    logic [5:0] sens_code;
    logic [4:0] voq_code;
    logic       locked, blow_req, blow_err;
    logic [2:0] blow_bit, state;
    logic [1:0] blow_reg;
    int         n_chk = 0, n_bad = 0;
    bit         done = 0;
    logic       cap_req;
    logic [2:0] cap_bit;
    logic [1:0] cap_reg;

    always #10 clk = ~clk;

    trim_prog_ctrl dut (
        .clk(clk), .rst_n(rst_n), .fuse_init_n(fuse_init_n),
        .mid_evt(mid_evt), .high_evt(high_evt), .sens_code(sens_code),
        .voq_code(voq_code), .locked(locked), .blow_req(blow_req),
        .blow_bit(blow_bit), .blow_reg(blow_reg), .blow_err(blow_err),
        .state(state)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Power cycle: clears volatile state, fuses stay.
    task automatic power_cycle();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic mid(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) mid_evt = 1'b1;
            @(negedge clk) mid_evt = 1'b0;
        end
    endtask

    // High pulse; captures blow outputs in the cycle after the strobe.
    task automatic high();
        @(negedge clk) high_evt = 1'b1;
        @(negedge clk) high_evt = 1'b0;
        cap_req = blow_req; cap_bit = blow_bit; cap_reg = blow_reg;
    endtask

    task automatic go_addr(int k);
        high(); mid(k); high();
    endtask

    task automatic t_reset();
        @(negedge clk); rst_n = 1'b0; fuse_init_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; fuse_init_n = 1'b1;
        check("R1 state", state, 0);
        check("R1 blow_req", blow_req, 0);
        check("R1 blow_err", blow_err, 0);
        check("R10 sens blank", sens_code, 0);
        check("R10 lock blank", locked, 0);
    endtask

    task automatic t_init_ignore();
        mid(3);
        check("R1 mid ignored state", state, 0);
        check("R1 mid ignored sens", sens_code, 0);
    endtask

    task automatic t_first_blow();
        high();
        check("R2 to selection", state, 1);
        mid(1); high();
        check("R3 key1 to addressing", state, 2);
        mid(4);
        check("R4 sens trial 4", sens_code, 4);
        high();
        check("R5 blow_req", cap_req, 1);
        check("R5 blow_bit", cap_bit, 2);
        check("R5 blow_reg", cap_reg, 1);
        check("R5 halt", state, 3);
        @(negedge clk);
        check("R5 single cycle", blow_req, 0);
    endtask

    task automatic t_halt_ignore();
        mid(2); high();
        check("R6 halt state", state, 3);
        check("R6 halt sens", sens_code, 4);
        check("R6 no blow", cap_req, 0);
    endtask

    task automatic t_accumulate();
        power_cycle();
        check("R8 fuse kept", sens_code, 4);
        go_addr(1); mid(1);
        check("R8 or trial", sens_code, 5);
        high();
        check("R5 blow bit0", cap_bit, 0);
        power_cycle();
        check("R8 accumulated", sens_code, 5);
    endtask

    task automatic t_bad_blow();
        go_addr(1); mid(3);
        check("R8 or trial 7", sens_code, 7);
        high();
        check("R7 no req multi", cap_req, 0);
        check("R7 err multi", blow_err, 1);
        check("R7 halt", state, 3);
        power_cycle();
        check("R7 fuses unchanged", sens_code, 5);
        check("R1 err cleared", blow_err, 0);
        go_addr(1); high();
        check("R7 err zero code", blow_err, 1);
        check("R7 no req zero", cap_req, 0);
    endtask

    task automatic t_saturate();
        power_cycle();
        go_addr(2); mid(70);
        check("R4 saturate voq", voq_code, 31);
        check("R4 sens untouched", sens_code, 5);
        high();
        check("R7 no lock from multi", locked, 0);
    endtask

    task automatic t_bad_key();
        power_cycle();
        high(); high();
        check("R3 key0 void", state, 4);
        mid(2); high();
        check("R3 void holds", state, 4);
        check("R3 void codes", sens_code, 5);
        power_cycle();
        high(); mid(5);
        high();
        check("R2 key saturates void", state, 4);
    endtask

    task automatic t_voq_and_lock();
        power_cycle();
        go_addr(2); mid(8);
        check("R4 voq trial", voq_code, 8);
        high();
        check("R5 voq reg", cap_reg, 2);
        check("R5 voq bit", cap_bit, 3);
        power_cycle();
        check("R8 voq kept", voq_code, 8);
        go_addr(2); mid(32);
        check("R9 lock trial not locked", locked, 0);
        check("R4 voq with bit5 trial", voq_code, 8);
        high();
        check("R9 lock bit", cap_bit, 5);
        power_cycle();
        check("R9 locked", locked, 1);
        high();
        check("R9 high ignored", state, 0);
        mid(2); high();
        check("R9 still initial", state, 0);
        check("R9 sens frozen", sens_code, 5);
    endtask

    task automatic t_fuse_init();
        @(negedge clk) fuse_init_n = 1'b0;
        @(negedge clk) fuse_init_n = 1'b1;
        check("R10 sens cleared", sens_code, 0);
        check("R10 voq cleared", voq_code, 0);
        check("R10 lock cleared", locked, 0);
    endtask

    initial begin
        t_reset();
        t_init_ignore();
        t_first_blow();
        t_halt_ignore();
        t_accumulate();
        t_bad_blow();
        t_saturate();
        t_bad_key();
        t_voq_and_lock();
        t_fuse_init();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule